// File: doc/BRIEF.md
# I2C Single-Master Transaction Controller

This block runs complete transfers on a two-wire I2C bus where it is the only master. It never drives either line high. Each line has an output enable that pulls it low when asserted. When the enable is released, the external pull-up brings the line high. The controller reads the data line back to collect acknowledge bits and read data.

A single command carries the 7-bit target address, a count of bytes to write and a count of bytes to read. A nonzero write count together with a nonzero read count makes one combined transfer. The write phase is joined to the read phase by a repeated START, and one STOP closes the whole transfer.

Write bytes are pulled from a data input. Each time the controller latches a write byte it pulses a take strobe. Each received byte appears with a one-cycle valid strobe. A command-level select chooses between a standard-rate and a fast-rate SCL. The rate is derived from two divider parameters that count system clocks per quarter of an SCL period.

Top module: `i2cm_ctrl`

## Requirements
- R1: After reset and whenever `busy` is low, `scl_oe` and `sda_oe` are both 0, so both lines are released. An output enable of 1 pulls the line low, and a high level comes only from the pull-up.
- R2: A START is SDA falling while SCL stays high. A STOP is SDA rising while SCL stays high. Every other SDA change made by the controller happens while SCL is low. Each transfer has exactly one STOP, and it comes last.
- R3: Each byte takes nine SCL pulses. The first eight carry the bits, most significant bit first. During the ninth the transmitter releases SDA so the receiver can acknowledge: low means ACK and high means NACK.
- R4: The first byte after every START or repeated START is `{addr[6:0], rw}`. The bit rw is 0 for a write and 1 for a read.
- R5: When the write count is nonzero, exactly that many bytes are sent from `wr_data`, in order. `wr_take` pulses once in the cycle after each byte is latched.
- R6: When the read count is nonzero, that many bytes are returned on `rd_data`, each with a one-cycle `rd_valid` pulse. The controller ACKs every read byte (SDA low) except the last, which it NACKs before the STOP.
- R7: When both counts are nonzero, the write phase is followed by a repeated START with no STOP in between, and then by the address with rw=1.
- R8: A NACK on an address or write byte stops the transfer with a STOP after that byte. No further bytes are taken or read, and `nack_err` goes to 1. `nack_err` stays 1 until the next command is accepted, and is 0 otherwise.
- R9: `busy` rises in the cycle after `cmd_valid` is accepted while idle. It falls when the STOP completes. A `cmd_valid` seen while `busy` is high starts nothing and does not alter the transfer in progress.
- R10: Let Q be `QTR_FAST` when `cmd_fast` is 1 and `QTR_STD` otherwise. Inside a transfer, every SCL low phase lasts 2Q system clocks. Every SCL high phase that lies between two low phases lasts 2Q+1 clocks.
- R11: A command with both counts zero sends only the address with rw=0, then a STOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Start a transfer (taken only when idle) |
| cmd_addr | input | 7 | Target address |
| cmd_wr_len | input | LEN_W | Number of bytes to write |
| cmd_rd_len | input | LEN_W | Number of bytes to read |
| cmd_fast | input | 1 | 1 selects the fast SCL rate, 0 the standard rate |
| wr_data | input | 8 | Next write byte, latched when needed |
| wr_take | output | 1 | Pulse: current `wr_data` was latched |
| rd_valid | output | 1 | Pulse: `rd_data` holds a received byte |
| rd_data | output | 8 | Received byte |
| busy | output | 1 | Transfer in progress |
| nack_err | output | 1 | Last transfer ended on a NACK |
| scl_oe | output | 1 | 1 pulls SCL low |
| sda_oe | output | 1 | 1 pulls SDA low |
| sda_in | input | 1 | SDA line level as read back |

## Verification
The bound checker watches several rules on every cycle:
- both lines are released whenever the controller is idle;
- a falling SDA edge under a high SCL happens only during a transfer;
- once SDA has risen under a high SCL, SCL is never pulled low again before `busy` drops;
- `nack_err` is clear at the start of each transfer;
- the two strobes never fire while idle or together.

Other behaviour needs the bench's bus-level target model and its scenarios. This covers the bit order, the address and direction bytes, the ACK/NACK pattern on reads, the repeated START in combined transfers, early termination on NACK, the ignoring of commands while busy, and the measured SCL phase lengths at both rates.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;

  typedef enum logic [1:0] {
    SYM_START  = 2'd0,
    SYM_RSTART = 2'd1,
    SYM_STOP   = 2'd2,
    SYM_BIT    = 2'd3
  } sym_e;

  typedef enum logic [2:0] {
    SQ_IDLE   = 3'd0,
    SQ_START  = 3'd1,
    SQ_TXB    = 3'd2,
    SQ_TACK   = 3'd3,
    SQ_RSTART = 3'd4,
    SQ_RXB    = 3'd5,
    SQ_MACK   = 3'd6,
    SQ_STOP   = 3'd7
  } seq_e;

  // Line levels {scl, sda} for one quarter of a symbol (1 = released).
  function automatic logic [1:0] sym_levels(input sym_e k, input logic [1:0] q,
                                            input logic b, input logic hold);
    logic [1:0] lv;
    case (k)
      SYM_START:  lv = (q < 2'd2) ? 2'b11 : 2'b10;
      SYM_RSTART: case (q)
                    2'd0: lv = {1'b0, hold};
                    2'd1: lv = 2'b01;
                    2'd2: lv = 2'b11;
                    default: lv = 2'b10;
                  endcase
      SYM_STOP:   case (q)
                    2'd0: lv = {1'b0, hold};
                    2'd1: lv = 2'b00;
                    2'd2: lv = 2'b10;
                    default: lv = 2'b11;
                  endcase
      default:    lv = (q == 2'd0) ? {1'b0, hold} : {(q >= 2'd2), b};
    endcase
    return lv;
  endfunction

endpackage

// File: rtl/i2cm_tick.sv
module i2cm_tick #(
  parameter int QTR_STD  = 500,
  parameter int QTR_FAST = 125
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic fast,
  output logic tick
);
  localparam int QMAX = (QTR_STD > QTR_FAST) ? QTR_STD : QTR_FAST;
  localparam int CW   = $clog2(QMAX + 1);

  logic [CW-1:0] cnt;
  logic [CW-1:0] lim;

  assign lim  = fast ? CW'(QTR_FAST - 1) : CW'(QTR_STD - 1);
  assign tick = run && (cnt == lim);

  always_ff @(posedge clk) begin
    if (rst || !run || tick) cnt <= '0;
    else                     cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/i2cm_phy.sv
module i2cm_phy
  import i2cm_pkg::*;
#(
  parameter int SYNC = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic go,
  input  sym_e kind,
  input  logic bit_in,
  input  logic sda_in,
  output logic active,
  output logic done,
  output logic rx_bit,
  output logic scl_oe,
  output logic sda_oe
);
  logic [1:0]      q;
  sym_e            kind_r;
  logic            bit_r;
  logic [SYNC-1:0] sync_q;
  logic [1:0]      lv_first;
  logic [1:0]      lv_next;

  generate
    if (SYNC > 1) begin : g_sync
      always_ff @(posedge clk) begin
        if (rst) sync_q <= '1;
        else     sync_q <= {sync_q[SYNC-2:0], sda_in};
      end
    end else begin : g_nosync
      always_ff @(posedge clk) begin
        if (rst) sync_q <= '1;
        else     sync_q <= sda_in;
      end
    end
  endgenerate

  assign lv_first = sym_levels(kind, 2'd0, bit_in, ~sda_oe);
  assign lv_next  = sym_levels(kind_r, q + 2'd1, bit_r, ~sda_oe);
  assign done     = active && tick && (q == 2'd3);

  always_ff @(posedge clk) begin
    if (rst) begin
      active <= 1'b0;
      q      <= 2'd0;
      kind_r <= SYM_BIT;
      bit_r  <= 1'b1;
      rx_bit <= 1'b1;
      scl_oe <= 1'b0;
      sda_oe <= 1'b0;
    end else if (!active && go) begin
      active           <= 1'b1;
      q                <= 2'd0;
      kind_r           <= kind;
      bit_r            <= bit_in;
      {scl_oe, sda_oe} <= ~lv_first;
    end else if (active && tick) begin
      if (q == 2'd2) rx_bit <= sync_q[SYNC-1];
      if (q == 2'd3) begin
        active <= 1'b0;
      end else begin
        q                <= q + 2'd1;
        {scl_oe, sda_oe} <= ~lv_next;
      end
    end
  end
endmodule

// File: rtl/i2cm_seq.sv
module i2cm_seq
  import i2cm_pkg::*;
#(
  parameter int LEN_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmd_valid,
  input  logic [6:0]       cmd_addr,
  input  logic [LEN_W-1:0] cmd_wr_len,
  input  logic [LEN_W-1:0] cmd_rd_len,
  input  logic             cmd_fast,
  input  logic [7:0]       wr_data,
  output logic             wr_take,
  output logic             rd_valid,
  output logic [7:0]       rd_data,
  output logic             busy,
  output logic             nack_err,
  output logic             spd_fast,
  output logic             sym_go,
  output sym_e             sym_kind,
  output logic             sym_bit,
  input  logic             sym_done,
  input  logic             rx_bit
);
  seq_e             st;
  logic             issued;
  logic [6:0]       addr_r;
  logic             dir_r;
  logic [LEN_W-1:0] wr_left;
  logic [LEN_W-1:0] rd_left;
  logic [7:0]       sh;
  logic [2:0]       bcnt;

  assign sym_go = (st != SQ_IDLE) && !issued;

  always_comb begin
    case (st)
      SQ_START:  sym_kind = SYM_START;
      SQ_RSTART: sym_kind = SYM_RSTART;
      SQ_STOP:   sym_kind = SYM_STOP;
      default:   sym_kind = SYM_BIT;
    endcase
    case (st)
      SQ_TXB:  sym_bit = sh[7];
      SQ_MACK: sym_bit = (rd_left == '0);
      default: sym_bit = 1'b1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= SQ_IDLE;
      issued   <= 1'b0;
      addr_r   <= '0;
      dir_r    <= 1'b0;
      wr_left  <= '0;
      rd_left  <= '0;
      sh       <= '0;
      bcnt     <= '0;
      busy     <= 1'b0;
      nack_err <= 1'b0;
      spd_fast <= 1'b0;
      wr_take  <= 1'b0;
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      wr_take  <= 1'b0;
      rd_valid <= 1'b0;
      if (sym_go)   issued <= 1'b1;
      if (sym_done) issued <= 1'b0;
      case (st)
        SQ_IDLE: if (cmd_valid) begin
          addr_r   <= cmd_addr;
          wr_left  <= cmd_wr_len;
          rd_left  <= cmd_rd_len;
          spd_fast <= cmd_fast;
          dir_r    <= (cmd_wr_len == '0) && (cmd_rd_len != '0);
          busy     <= 1'b1;
          nack_err <= 1'b0;
          st       <= SQ_START;
        end
        SQ_START: if (sym_done) begin
          sh   <= {addr_r, dir_r};
          bcnt <= '0;
          st   <= SQ_TXB;
        end
        SQ_RSTART: if (sym_done) begin
          dir_r <= 1'b1;
          sh    <= {addr_r, 1'b1};
          bcnt  <= '0;
          st    <= SQ_TXB;
        end
        SQ_TXB: if (sym_done) begin
          sh   <= {sh[6:0], 1'b0};
          bcnt <= bcnt + 3'd1;
          if (bcnt == 3'd7) st <= SQ_TACK;
        end
        SQ_TACK: if (sym_done) begin
          bcnt <= '0;
          if (rx_bit) begin
            nack_err <= 1'b1;
            st       <= SQ_STOP;
          end else if (dir_r) begin
            st <= SQ_RXB;
          end else if (wr_left != '0) begin
            sh      <= wr_data;
            wr_take <= 1'b1;
            wr_left <= wr_left - 1'b1;
            st      <= SQ_TXB;
          end else if (rd_left != '0) begin
            st <= SQ_RSTART;
          end else begin
            st <= SQ_STOP;
          end
        end
        SQ_RXB: if (sym_done) begin
          sh   <= {sh[6:0], rx_bit};
          bcnt <= bcnt + 3'd1;
          if (bcnt == 3'd7) begin
            rd_data  <= {sh[6:0], rx_bit};
            rd_valid <= 1'b1;
            rd_left  <= rd_left - 1'b1;
            st       <= SQ_MACK;
          end
        end
        SQ_MACK: if (sym_done) begin
          bcnt <= '0;
          st   <= (rd_left == '0) ? SQ_STOP : SQ_RXB;
        end
        default: if (sym_done) begin
          busy <= 1'b0;
          st   <= SQ_IDLE;
        end
      endcase
    end
  end
endmodule

// File: rtl/i2cm_ctrl.sv
module i2cm_ctrl
  import i2cm_pkg::*;
#(
  parameter int LEN_W    = 4,
  parameter int QTR_STD  = 500,
  parameter int QTR_FAST = 125,
  parameter int SYNC     = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmd_valid,
  input  logic [6:0]       cmd_addr,
  input  logic [LEN_W-1:0] cmd_wr_len,
  input  logic [LEN_W-1:0] cmd_rd_len,
  input  logic             cmd_fast,
  input  logic [7:0]       wr_data,
  output logic             wr_take,
  output logic             rd_valid,
  output logic [7:0]       rd_data,
  output logic             busy,
  output logic             nack_err,
  output logic             scl_oe,
  output logic             sda_oe,
  input  logic             sda_in
);
  logic spd_fast;
  logic sym_go;
  sym_e sym_kind;
  logic sym_bit;
  logic sym_done;
  logic rx_bit;
  logic phy_active;
  logic tick;

  i2cm_seq #(.LEN_W(LEN_W)) u_seq (
    .clk(clk), .rst(rst),
    .cmd_valid(cmd_valid), .cmd_addr(cmd_addr),
    .cmd_wr_len(cmd_wr_len), .cmd_rd_len(cmd_rd_len), .cmd_fast(cmd_fast),
    .wr_data(wr_data), .wr_take(wr_take),
    .rd_valid(rd_valid), .rd_data(rd_data),
    .busy(busy), .nack_err(nack_err), .spd_fast(spd_fast),
    .sym_go(sym_go), .sym_kind(sym_kind), .sym_bit(sym_bit),
    .sym_done(sym_done), .rx_bit(rx_bit)
  );

  i2cm_tick #(.QTR_STD(QTR_STD), .QTR_FAST(QTR_FAST)) u_tick (
    .clk(clk), .rst(rst), .run(phy_active), .fast(spd_fast), .tick(tick)
  );

  i2cm_phy #(.SYNC(SYNC)) u_phy (
    .clk(clk), .rst(rst), .tick(tick),
    .go(sym_go), .kind(sym_kind), .bit_in(sym_bit), .sda_in(sda_in),
    .active(phy_active), .done(sym_done), .rx_bit(rx_bit),
    .scl_oe(scl_oe), .sda_oe(sda_oe)
  );
endmodule

// File: rtl/i2cm_ctrl_chk.sv
module i2cm_ctrl_chk (
  input logic clk,
  input logic rst,
  input logic busy,
  input logic nack_err,
  input logic scl_oe,
  input logic sda_oe,
  input logic rd_valid,
  input logic wr_take
);
  logic p_ok, p_scl_oe, p_sda_oe, stop_seen;
  logic ev_start, ev_stop;

  assign ev_start = p_ok && !p_scl_oe && !scl_oe && !p_sda_oe && sda_oe;
  assign ev_stop  = p_ok && !p_scl_oe && !scl_oe && p_sda_oe && !sda_oe;

  always_ff @(posedge clk) begin
    if (rst) begin
      p_ok      <= 1'b0;
      p_scl_oe  <= 1'b0;
      p_sda_oe  <= 1'b0;
      stop_seen <= 1'b0;
    end else begin
      p_ok     <= 1'b1;
      p_scl_oe <= scl_oe;
      p_sda_oe <= sda_oe;
      if (!busy)        stop_seen <= 1'b0;
      else if (ev_stop) stop_seen <= 1'b1;
    end
  end

  // R1: lines released while idle
  a_r1_idle_released: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (!scl_oe && !sda_oe)) else $error("a_r1_idle_released");

  // R2: SDA falls under a high SCL only inside a transfer
  a_r2_start_in_txn: assert property (@(posedge clk) disable iff (rst)
    ev_start |-> busy) else $error("a_r2_start_in_txn");

  // R2: after the STOP edge SCL stays released until busy drops
  a_r2_stop_last: assert property (@(posedge clk) disable iff (rst)
    stop_seen |-> !scl_oe) else $error("a_r2_stop_last");

  // R8: nack flag cleared when a transfer starts
  a_r8_nack_cleared: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> !nack_err) else $error("a_r8_nack_cleared");

  // R5: write byte taken only during a transfer
  a_r5_take_in_txn: assert property (@(posedge clk) disable iff (rst)
    wr_take |-> (busy && !rd_valid)) else $error("a_r5_take_in_txn");

  // R6: read byte delivered only during a transfer
  a_r6_rdv_in_txn: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> busy) else $error("a_r6_rdv_in_txn");
endmodule

bind i2cm_ctrl i2cm_ctrl_chk u_chk (
  .clk(clk), .rst(rst), .busy(busy), .nack_err(nack_err),
  .scl_oe(scl_oe), .sda_oe(sda_oe), .rd_valid(rd_valid), .wr_take(wr_take)
);

// File: tb/i2cm_ctrl_bench.sv
module i2cm_ctrl_bench;
  localparam int LEN_W = 3;
  localparam int QS = 8;
  localparam int QF = 3;
  localparam logic [6:0] SLV = 7'h52;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cmd_valid = 1'b0;
  logic [6:0] cmd_addr = '0;
  logic [LEN_W-1:0] cmd_wr_len = '0;
  logic [LEN_W-1:0] cmd_rd_len = '0;
  logic cmd_fast = 1'b0;
  logic [7:0] wr_data;
  logic wr_take, rd_valid, busy, nack_err, scl_oe, sda_oe;
  logic [7:0] rd_data;
  logic s_pull = 1'b0;
  logic scl_line, sda_line;

  assign scl_line = ~scl_oe;
  assign sda_line = ~(sda_oe | s_pull);

  always #2.5 clk = ~clk;

  i2cm_ctrl #(.LEN_W(LEN_W), .QTR_STD(QS), .QTR_FAST(QF)) u_i2cm_ctrl (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_addr(cmd_addr),
    .cmd_wr_len(cmd_wr_len), .cmd_rd_len(cmd_rd_len), .cmd_fast(cmd_fast),
    .wr_data(wr_data), .wr_take(wr_take), .rd_valid(rd_valid), .rd_data(rd_data),
    .busy(busy), .nack_err(nack_err), .scl_oe(scl_oe), .sda_oe(sda_oe),
    .sda_in(sda_line)
  );

  function automatic logic [7:0] wdat(input int i);
    return 8'(8'hC3 + i * 53);
  endfunction
  function automatic logic [7:0] rbyte(input int i);
    return 8'h5A ^ 8'(i * 29 + 3);
  endfunction

  int vectors = 0, fails = 0;
  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // write-data feed and read capture
  int n_take = 0, take_base = 0, n_rdv = 0;
  logic [7:0] rd_log [256];
  assign wr_data = wdat(n_take - take_base);
  always @(negedge clk) begin
    if (!rst && wr_take) n_take++;
    if (!rst && rd_valid) begin rd_log[n_rdv] = rd_data; n_rdv++; end
  end

  // bus-level target model
  int n_start = 0, n_stop = 0, n_rstart = 0, n_addr = 0, n_wr = 0, n_mack = 0;
  logic [7:0] addr_log [256];
  logic [7:0] wr_log [256];
  logic       mack_log [256];
  int slave_nack_wr = 0;
  logic p_scl = 1'b1, p_sda = 1'b1, in_txn = 1'b0, addr_ph = 1'b0, xmit = 1'b0;
  logic rd_mode = 1'b0, last_ack = 1'b0, mst_ack = 1'b0;
  logic [7:0] rx_sh = '0, tx_sh = '0;
  int sbc = 0, txn_wr = 0, txn_rd = 0;

  always @(negedge clk) begin
    logic cs, cd;
    cs = scl_line; cd = sda_line;
    if (rst) begin
      in_txn = 0; xmit = 0; s_pull = 0; sbc = 0;
    end else if (p_scl && cs && p_sda && !cd) begin
      n_start++;
      if (in_txn) n_rstart++;
      else begin txn_wr = 0; txn_rd = 0; end
      in_txn = 1; sbc = 0; addr_ph = 1; xmit = 0; s_pull = 0;
    end else if (p_scl && cs && !p_sda && cd) begin
      n_stop++; in_txn = 0; xmit = 0; s_pull = 0;
    end else if (in_txn && !p_scl && cs) begin
      if (sbc < 8) begin rx_sh = {rx_sh[6:0], cd}; sbc++; end
      else if (sbc == 8) begin
        if (xmit) begin mack_log[n_mack] = cd; n_mack++; mst_ack = !cd; end
        sbc = 9;
      end
    end else if (in_txn && p_scl && !cs) begin
      if (sbc == 8) begin
        if (!xmit) begin
          if (addr_ph) begin
            addr_log[n_addr] = rx_sh; n_addr++;
            last_ack = (rx_sh[7:1] == SLV); rd_mode = rx_sh[0];
          end else begin
            wr_log[n_wr] = rx_sh; n_wr++; txn_wr++;
            last_ack = (slave_nack_wr != txn_wr);
          end
          s_pull = last_ack;
        end else s_pull = 0;
      end else if (sbc == 9) begin
        sbc = 0; s_pull = 0;
        if (addr_ph) begin addr_ph = 0; xmit = last_ack && rd_mode; end
        else if (xmit) xmit = mst_ack;
        if (xmit) begin tx_sh = rbyte(txn_rd); txn_rd++; s_pull = !tx_sh[7]; end
      end else if (sbc >= 1 && sbc <= 7 && xmit) s_pull = !tx_sh[7 - sbc];
    end
    p_scl = cs; p_sda = cd;
  end

  // SCL phase-length monitor
  int qexp = QS, run_len = 0, bad_hi = 0, bad_lo = 0, n_meas = 0;
  logic armed = 1'b0, m_scl = 1'b1;
  always @(negedge clk) begin
    if (rst || !busy) begin
      armed = 0; run_len = 0; m_scl = scl_line;
    end else if (scl_line == m_scl) run_len++;
    else begin
      if (armed) begin
        n_meas++;
        if (m_scl && run_len != 2 * qexp + 1) bad_hi++;
        if (!m_scl && run_len != 2 * qexp) bad_lo++;
      end
      armed = 1; run_len = 1; m_scl = scl_line;
    end
  end

  task automatic run_txn(input logic fast, input int wl, input int rl,
                         input logic [6:0] addr, input int nack_wr, input bit poke);
    int b_start, b_stop, b_rst, b_addr, b_wr, b_mack, b_rdv;
    int e_wr, e_rd, e_rst, e_addr;
    bit e_nack;
    b_start = n_start; b_stop = n_stop; b_rst = n_rstart; b_addr = n_addr;
    b_wr = n_wr; b_mack = n_mack; b_rdv = n_rdv; take_base = n_take;
    bad_hi = 0; bad_lo = 0; n_meas = 0;
    qexp = fast ? QF : QS;
    slave_nack_wr = nack_wr;
    if (addr != SLV) begin
      e_wr = 0; e_rd = 0; e_nack = 1; e_rst = 0; e_addr = 1;
    end else if (nack_wr > 0 && nack_wr <= wl) begin
      e_wr = nack_wr; e_rd = 0; e_nack = 1; e_rst = 0; e_addr = 1;
    end else begin
      e_wr = wl; e_rd = rl; e_nack = 0;
      e_rst = (wl > 0 && rl > 0) ? 1 : 0; e_addr = 1 + e_rst;
    end
    @(negedge clk);
    cmd_addr = addr; cmd_wr_len = LEN_W'(wl); cmd_rd_len = LEN_W'(rl);
    cmd_fast = fast; cmd_valid = 1;
    @(negedge clk);
    cmd_valid = 0;
    chk(busy == 1, "R9", "busy after accept", busy, 1);
    chk(nack_err == 0, "R8", "nack_err cleared on accept", nack_err, 0);
    if (poke) begin
      repeat (60) @(negedge clk);
      cmd_addr = ~SLV; cmd_wr_len = '1; cmd_fast = ~fast; cmd_valid = 1;
      @(negedge clk);
      cmd_valid = 0;
    end
    while (busy) @(negedge clk);
    repeat (4) @(negedge clk);
    chk(n_start - b_start == 1 + e_rst, "R2", "START count", n_start - b_start, 1 + e_rst);
    chk(n_stop - b_stop == 1, "R2", "STOP count", n_stop - b_stop, 1);
    chk(n_rstart - b_rst == e_rst, "R7", "repeated START count", n_rstart - b_rst, e_rst);
    chk(n_addr - b_addr == e_addr, "R4", "address bytes", n_addr - b_addr, e_addr);
    if (n_addr - b_addr >= 1) begin
      logic [7:0] ea;
      ea = {addr, (wl == 0 && rl > 0) ? 1'b1 : 1'b0};
      chk(addr_log[b_addr] == ea, "R4", "first address byte", addr_log[b_addr], ea);
    end
    if (e_addr == 2 && n_addr - b_addr == 2)
      chk(addr_log[b_addr + 1] == {addr, 1'b1}, "R7", "address after repeated START",
          addr_log[b_addr + 1], {addr, 1'b1});
    chk(n_take - take_base == e_wr, "R5", "wr_take pulses", n_take - take_base, e_wr);
    chk(n_wr - b_wr == e_wr, "R5", "bytes seen on bus", n_wr - b_wr, e_wr);
    for (int i = 0; i < e_wr && i < n_wr - b_wr; i++)
      chk(wr_log[b_wr + i] == wdat(i), "R3", "write byte MSB first", wr_log[b_wr + i], wdat(i));
    chk(n_rdv - b_rdv == e_rd, "R6", "rd_valid pulses", n_rdv - b_rdv, e_rd);
    for (int i = 0; i < e_rd && i < n_rdv - b_rdv; i++)
      chk(rd_log[b_rdv + i] == rbyte(i), "R6", "read byte", rd_log[b_rdv + i], rbyte(i));
    chk(n_mack - b_mack == e_rd, "R6", "master ack clocks", n_mack - b_mack, e_rd);
    for (int i = 0; i < e_rd && i < n_mack - b_mack; i++)
      chk(mack_log[b_mack + i] == (i == e_rd - 1), "R6", "master ACK/NACK bit",
          mack_log[b_mack + i], (i == e_rd - 1));
    chk(nack_err == e_nack, "R8", "nack_err", nack_err, e_nack);
    chk(!scl_oe && !sda_oe && !busy, "R1", "released after STOP", {scl_oe, sda_oe, busy}, 0);
    chk(bad_hi == 0 && bad_lo == 0 && n_meas > 0, "R10", "SCL phase lengths",
        bad_hi + bad_lo, 0);
    if (wl == 0 && rl == 0)
      chk(n_addr - b_addr == 1 && n_wr - b_wr == 0, "R11", "probe sends address only",
          n_addr - b_addr, 1);
    if (poke) begin
      int s0;
      s0 = n_start;
      repeat (100) @(negedge clk);
      chk(!busy && n_start == s0, "R9", "command during busy ignored", n_start - s0, 0);
    end
  endtask

  initial begin
    #(5.0 * 150000);
    vectors++; fails++;
    $display("FAIL watchdog: actual running expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk(!scl_oe && !sda_oe, "R1", "lines released after reset", {scl_oe, sda_oe}, 0);
    chk(!busy && !nack_err, "R9", "idle after reset", {busy, nack_err}, 0);
    for (int f = 0; f < 2; f++)
      for (int wl = 0; wl < 3; wl++)
        for (int rl = 0; rl < 3; rl++)
          run_txn(f[0], wl, rl, SLV, 0, 0);
    run_txn(0, 2, 1, 7'h11, 0, 0);
    run_txn(1, 3, 2, SLV, 2, 0);
    run_txn(0, 3, 0, SLV, 1, 0);
    run_txn(0, 1, 1, SLV, 0, 1);
    run_txn(1, 0, 3, SLV, 0, 0);
    run_txn(0, 4, 0, SLV, 0, 0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule